// File: doc/BRIEF.md
# Transport Stream Output Formatter

This block sits at the output of a broadcast receiver's decoding chain. It takes decoded transport packets as a byte stream and drives the external stream port. The port carries an output clock, a data bus, a data-valid strobe, a packet-sync strobe, a flag marking packets the error decoder could not repair, and a superframe-start pulse. Packets are 188 bytes long, and each begins with the sync byte (normally 0x47). Packets are framed only by the start-of-packet input; the byte value is never checked.

Time is divided into output slots of two system clock cycles. The output clock is high in the first cycle of a slot and low in the second. All outputs are registered and change only when a slot begins. In parallel mode one byte fills one slot. In serial mode a byte is sent most-significant bit first on bit 0 of the bus, one bit per slot. A bypass mode puts a raw inner-decoder bit stream on bit 0 instead. Each strobe and flag has its own static polarity bit, and a further bit moves data changes from the rising to the falling output clock edge. The input side is paced by a ready signal.

Top module: `ts_out_fmt`

## Requirements
- R1: A slot lasts two clk cycles. `ts_clk` equals `cfg_clk_fall` in the second cycle and its inverse in the first. No output changes except in the first cycle of a slot.
- R2: In serial mode (`cfg_serial`=1, `cfg_bypass`=0), each accepted byte occupies 8 consecutive slots. Bit 7 goes first and bit 0 last, on `ts_data[0]`. `ts_data[7:1]` is 0.
- R3: In parallel mode each accepted byte appears on `ts_data` for one slot. Data-valid is active in every slot that carries packet data, including all 8 serial slots of a byte, and inactive otherwise. In an idle slot `ts_data` keeps its last value.
- R4: The sync strobe is active in exactly the slots of a byte accepted with `in_sop`=1, whatever the byte value.
- R5: `in_uncor` is sampled with the start-of-packet byte. The uncorrectable flag shows that value from the packet's first slot until the next packet's first slot, including idle gaps.
- R6: The frame-start output is active only in the first slot of a byte accepted with `in_sfs`=1.
- R7: `cfg_inv` bit 0 inverts data-valid, bit 1 the sync strobe, bit 2 the uncorrectable flag, and bit 3 frame-start. An output equals its active-high value XOR its bit.
- R8: In bypass mode (`cfg_bypass`=1), each slot takes one bit. When `vit_valid` is 1 the bit appears on `ts_data[0]` with data-valid active and bits 7:1 zero. Sync, uncorrectable and frame-start stay inactive.
- R9: During synchronous reset `ts_data` is 0, every strobe sits at its inactive level, `ts_clk` equals `cfg_clk_fall`, and `in_ready` is 0.
- R10: `in_ready` is high only in the second cycle of a slot. In parallel and bypass modes it is high in every slot. In serial mode it is high only when the current byte's last bit is being sent or the serializer is idle. A byte is taken when `in_valid` and `in_ready` are both 1 at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_serial | input | 1 | 1 = serial output on bit 0 |
| cfg_bypass | input | 1 | 1 = raw bit stream bypass (overrides serial) |
| cfg_clk_fall | input | 1 | 1 = data changes on falling output clock edge |
| cfg_inv | input | 4 | Polarity bits: valid, sync, uncorrectable, frame-start |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Byte or bypass bit taken at next edge |
| in_data | input | DW | Input byte |
| in_sop | input | 1 | Byte is first of a packet |
| in_uncor | input | 1 | Packet failed decoding (sampled with in_sop) |
| in_sfs | input | 1 | Byte starts a superframe |
| vit_valid | input | 1 | Bypass bit present |
| vit_bit | input | 1 | Bypass bit value |
| ts_clk | output | 1 | Output clock |
| ts_data | output | DW | Output data bus |
| ts_den | output | 1 | Data-valid strobe |
| ts_sync | output | 1 | Packet-sync strobe |
| ts_uncor | output | 1 | Uncorrectable-packet flag |
| ts_fstart | output | 1 | Superframe-start pulse |

## Verification
Randomly filled packets are driven in parallel and serial modes, both back-to-back and with random idle gaps. Back-to-back traffic shows the slot rate and the `in_ready` pacing. The gaps show that data holds and the uncorrectable flag persists between bytes. Random polarity words and the falling-edge clock option separate inversion from the active-high logic. A packet whose first byte is not 0x47, superframe marks on single bytes, and a random bypass bit stream cover framing by start-of-packet alone, the one-slot pulse, and the bypass path.

// File: rtl/ts_fmt_pkg.sv
`timescale 1ns/1ps
package ts_fmt_pkg;
  localparam int STB_DEN  = 0;
  localparam int STB_SYNC = 1;
  localparam int STB_UNC  = 2;
  localparam int STB_FS   = 3;
  localparam int NSTB     = 4;

  typedef enum logic [1:0] {
    MODE_PAR = 2'd0,
    MODE_SER = 2'd1,
    MODE_BYP = 2'd2
  } out_mode_e;
endpackage

// File: rtl/ts_slot_timer.sv
`timescale 1ns/1ps
// Two-cycle slot timing: 'load' marks the cycle whose closing edge starts a slot.
module ts_slot_timer (
  input  logic clk,
  input  logic rst,
  input  logic clk_fall,
  output logic load,
  output logic oclk
);
  logic ph_q;
  logic oclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= 1'b0;
      oclk_q <= clk_fall;
    end else begin
      ph_q   <= ~ph_q;
      oclk_q <= ph_q ^ clk_fall;
    end
  end

  assign load = ph_q;
  assign oclk = oclk_q;
endmodule

// File: rtl/ts_byte_engine.sv
`timescale 1ns/1ps
// Chooses what the next slot carries: a byte, a serial bit, a bypass bit or idle.
module ts_byte_engine
  import ts_fmt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  out_mode_e       mode,
  input  logic            load,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DW-1:0]   in_data,
  input  logic            in_sop,
  input  logic            in_uncor,
  input  logic            in_sfs,
  input  logic            vit_valid,
  input  logic            vit_bit,
  output logic [DW-1:0]   nxt_data,
  output logic [NSTB-1:0] nxt_stb
);
  localparam int CW = (DW > 2) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(DW - 1);

  logic [DW-2:0] shift_q;
  logic [CW-1:0] left_q;
  logic          sop_q;
  logic          unc_q;
  logic          take_byte;
  logic          unc_now;

  assign in_ready  = load && ((mode != MODE_SER) || (left_q == '0));
  assign take_byte = in_ready && in_valid && (mode != MODE_BYP);
  assign unc_now   = (take_byte && in_sop) ? in_uncor : unc_q;

  always_comb begin
    nxt_data = '0;
    nxt_stb  = '0;
    unique case (mode)
      MODE_BYP: begin
        nxt_data[0]       = vit_bit;
        nxt_stb[STB_DEN]  = vit_valid;
      end
      MODE_SER: begin
        nxt_stb[STB_UNC] = unc_now;
        if (left_q != '0) begin
          nxt_data[0]       = shift_q[DW-2];
          nxt_stb[STB_DEN]  = 1'b1;
          nxt_stb[STB_SYNC] = sop_q;
        end else if (take_byte) begin
          nxt_data[0]       = in_data[DW-1];
          nxt_stb[STB_DEN]  = 1'b1;
          nxt_stb[STB_SYNC] = in_sop;
          nxt_stb[STB_FS]   = in_sfs;
        end
      end
      default: begin
        nxt_stb[STB_UNC] = unc_now;
        if (take_byte) begin
          nxt_data          = in_data;
          nxt_stb[STB_DEN]  = 1'b1;
          nxt_stb[STB_SYNC] = in_sop;
          nxt_stb[STB_FS]   = in_sfs;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      left_q  <= '0;
      sop_q   <= 1'b0;
      unc_q   <= 1'b0;
    end else if (load) begin
      if (mode == MODE_SER) begin
        if (left_q != '0) begin
          shift_q <= shift_q << 1;
          left_q  <= left_q - 1'b1;
        end else if (take_byte) begin
          shift_q <= in_data[DW-2:0];
          left_q  <= LAST_IDX;
          sop_q   <= in_sop;
        end
      end
      if (take_byte && in_sop) begin
        unc_q <= in_uncor;
      end
    end
  end
endmodule

// File: rtl/ts_out_stage.sv
`timescale 1ns/1ps
// Output registers with per-strobe polarity; data holds while no valid slot.
module ts_out_stage
  import ts_fmt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [NSTB-1:0] inv,
  input  logic [DW-1:0]   nxt_data,
  input  logic [NSTB-1:0] nxt_stb,
  output logic [DW-1:0]   data,
  output logic [NSTB-1:0] stb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
    end else if (load && nxt_stb[STB_DEN]) begin
      data <= nxt_data;
    end
  end

  for (genvar i = 0; i < NSTB; i++) begin : g_stb
    always_ff @(posedge clk) begin
      if (rst) begin
        stb[i] <= inv[i];
      end else if (load) begin
        stb[i] <= nxt_stb[i] ^ inv[i];
      end
    end
  end
endmodule

// File: rtl/ts_out_fmt.sv
`timescale 1ns/1ps
module ts_out_fmt
  import ts_fmt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_serial,
  input  logic          cfg_bypass,
  input  logic          cfg_clk_fall,
  input  logic [3:0]    cfg_inv,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_sop,
  input  logic          in_uncor,
  input  logic          in_sfs,
  input  logic          vit_valid,
  input  logic          vit_bit,
  output logic          ts_clk,
  output logic [DW-1:0] ts_data,
  output logic          ts_den,
  output logic          ts_sync,
  output logic          ts_uncor,
  output logic          ts_fstart
);
  out_mode_e       mode;
  logic            load;
  logic [DW-1:0]   nxt_data;
  logic [NSTB-1:0] nxt_stb;
  logic [NSTB-1:0] stb;

  assign mode = cfg_bypass ? MODE_BYP : (cfg_serial ? MODE_SER : MODE_PAR);

  ts_slot_timer u_timer (
    .clk      (clk),
    .rst      (rst),
    .clk_fall (cfg_clk_fall),
    .load     (load),
    .oclk     (ts_clk)
  );

  ts_byte_engine #(.DW(DW)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .load      (load),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_sop    (in_sop),
    .in_uncor  (in_uncor),
    .in_sfs    (in_sfs),
    .vit_valid (vit_valid),
    .vit_bit   (vit_bit),
    .nxt_data  (nxt_data),
    .nxt_stb   (nxt_stb)
  );

  ts_out_stage #(.DW(DW)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .inv      (cfg_inv),
    .nxt_data (nxt_data),
    .nxt_stb  (nxt_stb),
    .data     (ts_data),
    .stb      (stb)
  );

  assign ts_den    = stb[STB_DEN];
  assign ts_sync   = stb[STB_SYNC];
  assign ts_uncor  = stb[STB_UNC];
  assign ts_fstart = stb[STB_FS];
endmodule

// File: rtl/ts_out_fmt_chk.sv
`timescale 1ns/1ps
module ts_out_fmt_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_serial,
  input logic          cfg_bypass,
  input logic          cfg_clk_fall,
  input logic [3:0]    cfg_inv,
  input logic          in_ready,
  input logic          ts_clk,
  input logic [DW-1:0] ts_data,
  input logic          ts_den,
  input logic          ts_sync,
  input logic          ts_uncor,
  input logic          ts_fstart
);
  logic ss, den_a, sync_a, unc_a, fs_a;
  assign ss     = ts_clk ^ cfg_clk_fall;
  assign den_a  = ts_den ^ cfg_inv[0];
  assign sync_a = ts_sync ^ cfg_inv[1];
  assign unc_a  = ts_uncor ^ cfg_inv[2];
  assign fs_a   = ts_fstart ^ cfg_inv[3];

  p_data_at_slot_r1: assert property (@(posedge clk) disable iff (rst)
    (ts_data != $past(ts_data)) |-> ss);
  p_slot_one_cycle_r1: assert property (@(posedge clk) disable iff (rst)
    ss |=> !ss);
  p_serial_upper_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_serial && !cfg_bypass) |-> (ts_data[DW-1:1] == '0));
  p_sync_with_den_r4: assert property (@(posedge clk) disable iff (rst)
    sync_a |-> den_a);
  p_unc_change_at_sop_r5: assert property (@(posedge clk) disable iff (rst)
    (unc_a != $past(unc_a)) |-> sync_a);
  p_fs_with_den_r6: assert property (@(posedge clk) disable iff (rst)
    fs_a |-> den_a);
  p_bypass_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_bypass |-> !(sync_a || unc_a || fs_a));
  p_ready_phase_r10: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !ss);
endmodule

bind ts_out_fmt ts_out_fmt_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_serial   (cfg_serial),
  .cfg_bypass   (cfg_bypass),
  .cfg_clk_fall (cfg_clk_fall),
  .cfg_inv      (cfg_inv),
  .in_ready     (in_ready),
  .ts_clk       (ts_clk),
  .ts_data      (ts_data),
  .ts_den       (ts_den),
  .ts_sync      (ts_sync),
  .ts_uncor     (ts_uncor),
  .ts_fstart    (ts_fstart)
);

// File: tb/ts_out_fmt_tb.sv
`timescale 1ns/1ps
module ts_out_fmt_tb;
  localparam int DW = 8;
  localparam int PKT = 188;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_serial = 1'b0, cfg_bypass = 1'b0, cfg_clk_fall = 1'b0;
  logic [3:0] cfg_inv = 4'h0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_uncor = 1'b0, in_sfs = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic vit_valid = 1'b0, vit_bit = 1'b0;
  logic in_ready, ts_clk, ts_den, ts_sync, ts_uncor, ts_fstart;
  logic [DW-1:0] ts_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int last_take = -1;
  logic [10:0] q_exp[$];   // {fs, unc, sync, data}
  logic [DW-1:0] prev_data;
  logic prev_ss = 1'b0;
  logic last_unc = 1'b0;

  always #5 clk = ~clk;

  ts_out_fmt #(.DW(DW)) u_dut (
    .clk(clk), .rst(rst), .cfg_serial(cfg_serial), .cfg_bypass(cfg_bypass),
    .cfg_clk_fall(cfg_clk_fall), .cfg_inv(cfg_inv), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_sop(in_sop), .in_uncor(in_uncor),
    .in_sfs(in_sfs), .vit_valid(vit_valid), .vit_bit(vit_bit), .ts_clk(ts_clk),
    .ts_data(ts_data), .ts_den(ts_den), .ts_sync(ts_sync), .ts_uncor(ts_uncor),
    .ts_fstart(ts_fstart)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [10:0] slot_rec(input logic fs, input logic unc,
                                           input logic sy, input logic [DW-1:0] d);
    return {fs, unc, sy, d};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  // Slot monitor
  always @(negedge clk) begin
    logic ss, den, sy, un, fs;
    logic [10:0] e;
    if (rst) begin
      prev_data = ts_data;
      prev_ss   = 1'b0;
      last_unc  = 1'b0;
    end else begin
      ss  = ts_clk ^ cfg_clk_fall;
      den = ts_den ^ cfg_inv[0];
      sy  = ts_sync ^ cfg_inv[1];
      un  = ts_uncor ^ cfg_inv[2];
      fs  = ts_fstart ^ cfg_inv[3];
      if (ss) begin
        chk(!prev_ss, "R1 slot start lasts one cycle", prev_ss, 0);
        if (den) begin
          if (q_exp.size() == 0) begin
            chk(1'b0, "R3 unexpected valid slot", ts_data, 0);
          end else begin
            e = q_exp.pop_front();
            chk(ts_data == e[7:0], "R3 data (R2 serial bit / R8 bypass)", ts_data, e[7:0]);
            chk(sy == e[8], "R4 sync strobe", sy, e[8]);
            chk(un == e[9], "R5 uncorrectable flag", un, e[9]);
            chk(fs == e[10], "R6 frame start", fs, e[10]);
            last_unc = e[9];
          end
        end else begin
          chk(ts_data == prev_data, "R3 idle data hold", ts_data, prev_data);
          chk(!sy, "R4 idle sync", sy, 0);
          chk(!fs, "R6 idle frame start", fs, 0);
          chk(un == last_unc, "R5 flag held in gap", un, last_unc);
        end
      end else begin
        chk(ts_data == prev_data, "R1 data changes only at slot start", ts_data, prev_data);
      end
      prev_data = ts_data;
      prev_ss   = ss;
    end
  end

  task automatic do_reset(input logic ser, input logic byp, input logic fall,
                          input logic [3:0] inv);
    rst = 1'b1;
    cfg_serial = ser; cfg_bypass = byp; cfg_clk_fall = fall; cfg_inv = inv;
    last_take = -1;
    repeat (4) @(negedge clk);
    chk(ts_data == '0, "R9 reset data", ts_data, 0);
    chk({ts_fstart, ts_uncor, ts_sync, ts_den} == inv, "R9/R7 reset strobe levels",
        {ts_fstart, ts_uncor, ts_sync, ts_den}, inv);
    chk(ts_clk == fall, "R9 reset output clock", ts_clk, fall);
    chk(!in_ready, "R9 reset ready", in_ready, 0);
    rst = 1'b0;
  endtask

  task automatic send_byte(input logic [DW-1:0] d, input logic sop,
                           input logic unc, input logic sfs);
    in_valid = 1'b1; in_data = d; in_sop = sop; in_uncor = unc; in_sfs = sfs;
    while (!in_ready) @(negedge clk);
    if (last_take >= 0) begin
      if (cfg_serial)
        chk((cyc - last_take) >= 16 && ((cyc - last_take) % 2 == 0),
            "R10 serial take spacing", cyc - last_take, 16);
      else
        chk((cyc - last_take) >= 2 && ((cyc - last_take) % 2 == 0),
            "R10 parallel take spacing", cyc - last_take, 2);
    end
    last_take = cyc;
    if (cfg_serial) begin
      for (int i = 0; i < DW; i++)
        q_exp.push_back(slot_rec((i == 0) ? sfs : 1'b0, unc, sop,
                                 {{(DW-1){1'b0}}, d[DW-1-i]}));
    end else begin
      q_exp.push_back(slot_rec(sfs, unc, sop, d));
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_sfs = 1'b0;
  endtask

  task automatic send_packet(input logic unc, input int sfs_idx,
                             input logic [DW-1:0] first, input bit gaps);
    for (int i = 0; i < PKT; i++) begin
      send_byte((i == 0) ? first : DW'($urandom), i == 0, unc, i == sfs_idx);
      if (gaps && ($urandom % 4 == 0)) repeat ($urandom % 6) @(negedge clk);
    end
  endtask

  task automatic send_vit(input logic v, input logic b);
    vit_valid = v; vit_bit = b;
    while (!in_ready) @(negedge clk);
    if (v) q_exp.push_back(slot_rec(1'b0, 1'b0, 1'b0, {{(DW-1){1'b0}}, b}));
    @(negedge clk);
    vit_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while (q_exp.size() != 0 && n < 200) begin
      @(negedge clk);
      n++;
    end
    repeat (20) @(negedge clk);
    chk(q_exp.size() == 0, tag, q_exp.size(), 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0101));
    @(negedge clk);

    // Parallel, active-high, back-to-back then gapped (R1 R3 R4 R5 R6 R10)
    do_reset(1'b0, 1'b0, 1'b0, 4'h0);
    send_packet(1'b1, 0, 8'h47, 1'b0);
    send_packet(1'b0, 37, 8'h47, 1'b1);
    drain("R3 parallel all bytes shown");

    // Parallel, random polarity, falling-edge data (R7 R1); sync byte not 0x47 (R4)
    do_reset(1'b0, 1'b0, 1'b1, 4'($urandom));
    send_packet(1'b0, 5, 8'h12, 1'b1);
    send_packet(1'b1, 187, 8'h47, 1'b1);
    drain("R7 inverted parallel all bytes shown");

    // Serial, all strobes inverted, gaps (R2 R3 R5 R6 R7 R10)
    do_reset(1'b1, 1'b0, 1'b0, 4'hF);
    send_packet(1'b1, 0, 8'h47, 1'b1);
    send_packet(1'b0, 100, 8'h47, 1'b0);
    drain("R2 serial all bits shown");

    // Serial, random polarity, falling edge, corner bytes
    do_reset(1'b1, 1'b0, 1'b1, 4'($urandom));
    send_byte(8'hFF, 1'b1, 1'b1, 1'b1);
    send_byte(8'h00, 1'b0, 1'b1, 1'b0);
    repeat (9) @(negedge clk);
    send_byte(8'h81, 1'b0, 1'b1, 1'b1);
    send_byte(8'h47, 1'b1, 1'b0, 1'b0);
    drain("R2 serial corner bytes shown");

    // Bypass with serial also set: bypass wins (R8)
    do_reset(1'b1, 1'b1, 1'b0, 4'($urandom));
    in_valid = 1'b1; in_sop = 1'b1; in_uncor = 1'b1; in_sfs = 1'b1; in_data = 8'hA5;
    for (int i = 0; i < 300; i++) send_vit(($urandom % 4) != 0, 1'($urandom));
    in_valid = 1'b0; in_sop = 1'b0; in_uncor = 1'b0; in_sfs = 1'b0;
    drain("R8 bypass bits shown");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule